// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps time of day and calendar date as packed BCD bytes: seconds, minutes, hours (24-hour), day of week, date, month, year and century. A one-cycle pulse on `tick_1hz` advances the count by one second. Software reaches the clock through an eight-byte register window on a plain parallel bus with an address, write data, a read strobe, a write strobe and registered read data.

Two banks hold the time. The internal bank always counts, unless the oscillator stop bit is set. The visible bank is what bus reads return. It normally copies the internal count on every tick. A read-hold bit freezes the visible bank so that a multi-byte read sees one consistent instant, while the internal count keeps running. A write bit also freezes the visible bank, and while it is set, bus writes go into that bank. Clearing the write bit copies the whole visible bank into the internal counters in one cycle.

After either bit is cleared, the visible bank waits until both bits have been clear for `HOLD_CYC` system clock cycles. It then re-syncs on the next tick. This guarantees a minimum settle time before the visible bank follows the internal count again.

Top module: `rtc_dbuf_core`

## Requirements
- R1: After reset the visible registers read as follows: control 0x20, seconds 0x80 (oscillator stopped, 00 s), minutes 00, hours 00, date 01, month 01, year 00, day of week 01. The write bit and the read-hold bit are both 0.
- R2: The oscillator stop flag is bit 7 of the seconds register (window offset 1). It can be written whatever the state of the write bit, and it reads back. While it is 1, ticks do not advance the count.
- R3: While the write bit is 0, bus writes to the time fields leave the visible bank unchanged. This includes the century field in control bits 5:0.
- R4: While the write bit is 1, ticks do not update the visible bank, and bus writes go into it. A control write that clears the write bit loads the internal bank from the visible bank, including the century carried by that same write, so ticks seen while the bit was 1 are discarded.
- R5: Each tick while running advances the count. Seconds and minutes roll over from 59 to 00 and carry. Hours roll over from 23 to 00 and carry into the date.
- R6: The date rolls over to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and for month 02 it is 29 when the BCD year is divisible by 4 (00 included) and 28 otherwise.
- R7: At every date rollover the day of week advances and wraps from 07 to 01. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and carries into the century, and century 39 wraps to 00.
- R8: While the read-hold bit (control bit 6) is 1, the visible bank keeps the count it held when the bit was set. The internal bank keeps counting, so the visible bank shows every elapsed tick once it re-syncs.
- R9: After both control bits are clear, the visible bank re-syncs only on the first tick arriving at least `HOLD_CYC` cycles after the clear. A tick arriving earlier changes only the internal bank.
- R10: The window starts at `BASE` and holds these registers by offset:
  - 0: control {write, read-hold, century[5:0]}
  - 1: {osc stop, seconds[6:0]}
  - 2: minutes
  - 3: hours
  - 4: date
  - 5: month
  - 6: year
  - 7: day of week

  Read data appears one cycle after the read strobe. Addresses outside the window read 0x00. Without a strobe, the read data holds its value.
- R11: While both control bits are 0 and re-sync has occurred, each tick updates the visible bank to the newly advanced count on the same clock edge as the internal bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with `HOLD_CYC` = 8. This puts both sides of the re-sync threshold a few cycles apart, so an early-clear tick and a properly delayed tick fall in the same short sequence. With the default `BASE`, the bench sweeps more than an hour of ticks through a midnight crossing that carries from year 99 into the century. It also sets the last day of every month in a leap year and in a common year, and checks each rollover against a binary calendar model computed in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NREG = 8;
  // bank slot indices = window offsets
  localparam int IX_CEN = 0;
  localparam int IX_SEC = 1;
  localparam int IX_MIN = 2;
  localparam int IX_HR  = 3;
  localparam int IX_DAT = 4;
  localparam int IX_MON = 5;
  localparam int IX_YR  = 6;
  localparam int IX_DOW = 7;

  typedef logic [NREG-1:0][7:0] rtc_bank_t;

  function automatic logic [7:0] field_mask(input int idx);
    case (idx)
      IX_CEN:  return 8'h3F;
      IX_SEC:  return 8'h7F;
      IX_MIN:  return 8'h7F;
      IX_HR:   return 8'h3F;
      IX_DAT:  return 8'h3F;
      IX_MON:  return 8'h1F;
      IX_DOW:  return 8'h07;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_bin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] yb;
    yb = bcd_bin(yr);
    case (mon)
      8'h02: return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_adv.sv
module rtc_time_adv
  import rtc_pkg::*;
(
  input  rtc_bank_t cur,
  input  logic      en,
  output rtc_bank_t nxt
);
  logic [7:0] last_day;
  assign last_day = month_last(cur[IX_MON], cur[IX_YR]);

  always_comb begin
    nxt = cur;
    if (en) begin
      if (cur[IX_SEC] >= 8'h59) begin
        nxt[IX_SEC] = 8'h00;
        if (cur[IX_MIN] >= 8'h59) begin
          nxt[IX_MIN] = 8'h00;
          if (cur[IX_HR] >= 8'h23) begin
            nxt[IX_HR]  = 8'h00;
            nxt[IX_DOW] = (cur[IX_DOW] >= 8'h07) ? 8'h01 : bcd_inc(cur[IX_DOW]);
            if (cur[IX_DAT] >= last_day) begin
              nxt[IX_DAT] = 8'h01;
              if (cur[IX_MON] >= 8'h12) begin
                nxt[IX_MON] = 8'h01;
                if (cur[IX_YR] >= 8'h99) begin
                  nxt[IX_YR]  = 8'h00;
                  nxt[IX_CEN] = (cur[IX_CEN] >= 8'h39) ? 8'h00 : bcd_inc(cur[IX_CEN]);
                end else begin
                  nxt[IX_YR] = bcd_inc(cur[IX_YR]);
                end
              end else begin
                nxt[IX_MON] = bcd_inc(cur[IX_MON]);
              end
            end else begin
              nxt[IX_DAT] = bcd_inc(cur[IX_DAT]);
            end
          end else begin
            nxt[IX_HR] = bcd_inc(cur[IX_HR]);
          end
        end else begin
          nxt[IX_MIN] = bcd_inc(cur[IX_MIN]);
        end
      end else begin
        nxt[IX_SEC] = bcd_inc(cur[IX_SEC]);
      end
    end
  end
endmodule

// File: rtl/rtc_hold_sync.sv
module rtc_hold_sync #(
  parameter int HOLD_CYC = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic tick,
  output logic track,
  output logic armed,
  output logic copy_en
);
  localparam int HC     = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
  localparam int HOLD_W = $clog2(HC + 1);
  localparam logic [HOLD_W-1:0] HLIM = HOLD_W'(HC);

  logic [HOLD_W-1:0] cnt_q;
  logic              track_q;

  assign armed   = (cnt_q >= HLIM);
  assign track   = track_q;
  assign copy_en = tick && !hold_req && (track_q || armed);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      track_q <= 1'b1;
    end else if (hold_req) begin
      cnt_q   <= '0;
      track_q <= 1'b0;
    end else if (!track_q) begin
      if (armed) begin
        if (tick) track_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_regbus.sv
module rtc_regbus #(
  parameter int                ADDR_W = 15,
  parameter logic [ADDR_W-1:0] BASE   = 15'h7FF8,
  parameter int                NREG   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [NREG-1:0][7:0]       rd_vec,
  output logic [NREG-1:0]            wsel,
  output logic [7:0]                 rdata
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [ADDR_W-IDX_W-1:0] BASE_HI = BASE[ADDR_W-1:IDX_W];

  logic             hit;
  logic [IDX_W-1:0] idx;

  assign hit = (bus_addr[ADDR_W-1:IDX_W] == BASE_HI);
  assign idx = bus_addr[IDX_W-1:0];

  for (genvar k = 0; k < NREG; k++) begin : g_sel
    assign wsel[k] = bus_wr && hit && (idx == IDX_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= 8'h00;
    else if (bus_rd) rdata <= hit ? rd_vec[idx] : 8'h00;
  end
endmodule

// File: rtl/rtc_dbuf_core.sv
module rtc_dbuf_core
  import rtc_pkg::*;
#(
  parameter int                ADDR_W   = 15,
  parameter logic [ADDR_W-1:0] BASE     = 15'h7FF8,
  parameter int                HOLD_CYC = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata
);
  localparam logic [7:0] CEN_RST = 8'h20;

  rtc_bank_t       int_q, ext_q, ext_wr, int_adv;
  logic            osc_q, wbit_q, rbit_q;
  logic [NREG-1:0] wsel;
  rtc_bank_t       rd_vec;
  logic            hold_req, track, armed, copy_en, load_int;

  rtc_regbus #(.ADDR_W(ADDR_W), .BASE(BASE), .NREG(NREG)) u_bus (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .rd_vec(rd_vec), .wsel(wsel), .rdata(bus_rdata)
  );

  rtc_time_adv u_adv (
    .cur(int_q), .en(tick_1hz && !osc_q), .nxt(int_adv)
  );

  assign hold_req = wbit_q || rbit_q;

  rtc_hold_sync #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .hold_req(hold_req), .tick(tick_1hz),
    .track(track), .armed(armed), .copy_en(copy_en)
  );

  // visible bank after this cycle's bus write (only while write bit is set)
  for (genvar k = 0; k < NREG; k++) begin : g_extwr
    assign ext_wr[k] = (wsel[k] && wbit_q) ? (bus_wdata & field_mask(k)) : ext_q[k];
  end

  assign load_int = wsel[IX_CEN] && wbit_q && !bus_wdata[7];

  for (genvar k = 0; k < NREG; k++) begin : g_rd
    if (k == IX_CEN) begin : g_ctl
      assign rd_vec[k] = {wbit_q, rbit_q, ext_q[k][5:0]};
    end else if (k == IX_SEC) begin : g_sec
      assign rd_vec[k] = {osc_q, ext_q[k][6:0]};
    end else begin : g_plain
      assign rd_vec[k] = ext_q[k];
    end
  end

  function automatic rtc_bank_t bank_rst();
    rtc_bank_t b;
    b         = '0;
    b[IX_CEN] = CEN_RST;
    b[IX_DAT] = 8'h01;
    b[IX_MON] = 8'h01;
    b[IX_DOW] = 8'h01;
    return b;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q  <= bank_rst();
      ext_q  <= bank_rst();
      osc_q  <= 1'b1;
      wbit_q <= 1'b0;
      rbit_q <= 1'b0;
    end else begin
      int_q <= load_int ? ext_wr : int_adv;
      ext_q <= copy_en ? int_adv : ext_wr;
      if (wsel[IX_SEC]) osc_q <= bus_wdata[7];
      if (wsel[IX_CEN]) begin
        wbit_q <= bus_wdata[7];
        rbit_q <= bus_wdata[6];
      end
    end
  end
endmodule

// File: rtl/rtc_dbuf_chk.sv
module rtc_dbuf_chk
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      tick,
  input logic      bus_rd,
  input logic [7:0] bus_rdata,
  input logic      osc,
  input logic      rbit,
  input logic      wbit,
  input logic      load,
  input logic      track,
  input logic      armed,
  input rtc_bank_t int_bank,
  input rtc_bank_t ext_bank
);
  // R2
  osc_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (osc && !load) |=> (int_bank == $past(int_bank)));
  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (rbit && !wbit) |=> (ext_bank == $past(ext_bank)));
  // R4
  load_match_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (int_bank == ext_bank));
  // R9
  early_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !rbit && !wbit && !track && !armed) |=> (ext_bank == $past(ext_bank)));
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind rtc_dbuf_core rtc_dbuf_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick_1hz), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .osc(osc_q), .rbit(rbit_q), .wbit(wbit_q), .load(load_int),
  .track(track), .armed(armed), .int_bank(int_q), .ext_bank(ext_q)
);

// File: tb/sim_rtc_dbuf_core.sv
module sim_rtc_dbuf_core;
  localparam int HOLD = 8;
  localparam logic [14:0] BASE = 15'h7FF8;

  logic clk = 0, rst = 1, tick = 0, wr = 0, rd = 0;
  logic [14:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_dbuf_core #(.ADDR_W(15), .BASE(BASE), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst(rst), .tick_1hz(tick), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata)
  );

  // binary model of the expected count
  int ms, mm, mh, mdw, md, mmo, my, mc;
  bit mosc;
  logic [7:0] snap [8];

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic step_model();
    if (mosc) return;
    ms++;
    if (ms == 60) begin ms = 0; mm++; end
    if (mm == 60) begin mm = 0; mh++; end
    if (mh == 24) begin
      mh = 0;
      mdw = (mdw == 7) ? 1 : mdw + 1;
      md++;
      if (md > dim(mmo, my)) begin md = 1; mmo++; end
      if (mmo == 13) begin mmo = 1; my++; end
      if (my == 100) begin my = 0; mc = (mc == 39) ? 0 : mc + 1; end
    end
  endtask

  function automatic logic [7:0] model_reg(input int k);
    case (k)
      0: return {2'b00, bcd(mc)[5:0]};
      1: return {mosc, bcd(ms)[6:0]};
      2: return bcd(mm);
      3: return bcd(mh);
      4: return bcd(md);
      5: return bcd(mmo);
      6: return bcd(my);
      default: return bcd(mdw);
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int k, input logic [7:0] d);
    @(negedge clk);
    addr = BASE + 15'(k); wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd_addr(input logic [14:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = 1;
    @(negedge clk);
    rd = 0; v = rdata;
  endtask

  task automatic rd_reg(input int k, output logic [7:0] v);
    rd_addr(BASE + 15'(k), v);
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) begin
      rd_reg(k, v);
      check(req, v, model_reg(k));
    end
  endtask

  task automatic set_time(input int c, input int y, input int mo, input int d,
                          input int dw, input int h, input int mi, input int s);
    wr_reg(0, 8'h80);
    wr_reg(1, bcd(s)); wr_reg(2, bcd(mi)); wr_reg(3, bcd(h));
    wr_reg(4, bcd(d)); wr_reg(5, bcd(mo)); wr_reg(6, bcd(y)); wr_reg(7, bcd(dw));
    wr_reg(0, {2'b00, bcd(c)[5:0]});
    mc = c; my = y; mmo = mo; md = d; mdw = dw; mh = h; mm = mi; ms = s; mosc = 0;
    idle(HOLD + 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    mc = 20; my = 0; mmo = 1; md = 1; mdw = 1; mh = 0; mm = 0; ms = 0; mosc = 1;
    check_all("R1 reset");

    // R2: oscillator stopped, ticks do nothing
    pulse(); pulse();
    check_all("R2 osc stopped");

    // R3: time writes ignored with write bit clear; osc bit still writable (R2)
    wr_reg(2, 8'h33); wr_reg(0, 8'h15);
    check_all("R3 ignored write");
    wr_reg(1, 8'h00); mosc = 0;
    check_all("R2 osc cleared");
    pulse(); step_model();
    check_all("R11 tracking tick");

    // R10: outside window reads zero; rdata holds without strobe
    rd_addr(15'h0123, v); check("R10 unmapped", v, 8'h00);
    idle(3); check("R10 hold", rdata, 8'h00);

    // R4: set and load
    set_time(20, 23, 6, 15, 3, 10, 20, 30);
    pulse(); step_model();
    check_all("R4 set+tick");

    // R5, R6, R7: sweep through midnight, year and century carry
    set_time(19, 99, 12, 31, 7, 22, 59, 0);
    for (int t = 0; t < 3665; t++) begin
      pulse(); step_model();
      rd_reg(1, v); check("R5 sec", v, model_reg(1));
      rd_reg(2, v); check("R5 min", v, model_reg(2));
      rd_reg(3, v); check("R5 hour", v, model_reg(3));
      if (mh == 0 && mm == 0 && ms < 2) check_all("R7 midnight carry");
    end
    check_all("R7 century carry");

    // R6: last day of every month, leap and common years
    for (int yi = 0; yi < 3; yi++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        int y = (yi == 0) ? 24 : (yi == 1) ? 23 : 0;
        set_time(21, y, mo, dim(mo, y), 5, 23, 59, 59);
        pulse(); step_model();
        check_all("R6 month end");
      end
    end
    set_time(21, 24, 2, 28, 2, 23, 59, 59);
    pulse(); step_model();
    check_all("R6 leap feb28");

    // R7: century 39 wraps, day of week 7 wraps
    set_time(39, 99, 12, 31, 7, 23, 59, 59);
    pulse(); step_model();
    check_all("R7 century wrap");

    // R8: read-hold snapshot
    set_time(20, 30, 8, 10, 2, 12, 0, 0);
    pulse(); step_model();
    wr_reg(0, 8'h40);
    for (int k = 0; k < 8; k++) snap[k] = model_reg(k);
    snap[0] = 8'h40 | snap[0];
    for (int n = 0; n < 5; n++) begin pulse(); step_model(); end
    for (int k = 0; k < 8; k++) begin rd_reg(k, v); check("R8 frozen", v, snap[k]); end
    wr_reg(0, {2'b00, bcd(mc)[5:0]});
    idle(HOLD + 3);
    pulse(); step_model();
    check_all("R8 resync after hold");

    // R9: early clear does not re-sync
    wr_reg(0, 8'h40);
    for (int k = 1; k < 8; k++) snap[k] = model_reg(k);
    pulse(); step_model(); pulse(); step_model();
    wr_reg(0, 8'h00);
    pulse(); step_model();
    for (int k = 1; k < 8; k++) begin rd_reg(k, v); check("R9 early tick", v, snap[k]); end
    idle(HOLD + 3);
    pulse(); step_model();
    check_all("R9 late tick");

    // R4: ticks while write bit set are discarded on load
    wr_reg(0, 8'h80);
    for (int k = 1; k < 8; k++) snap[k] = model_reg(k);
    pulse(); pulse();
    rd_reg(1, v); check("R4 frozen sec", v, snap[1]);
    wr_reg(0, {2'b00, bcd(mc)[5:0]});
    idle(HOLD + 3);
    pulse(); step_model();
    check_all("R4 ticks discarded");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule